// File: doc/BRIEF.md
# Boot Mode Capture and Shared Interrupt Pin

This block sits between the board-level reset and mode pins and the processor core. A raw, asynchronous active-low reset puts the internal reset into force at once. When the raw reset is released, the release passes through a chain of flops clocked by the core clock before the internal reset lets go. On the clock edge where the internal reset releases, the block samples a bus of mode pins into an operating-mode register. That register then holds its value until the next reset.

After reset, one of the mode pins becomes an active-low external interrupt request. The pin is synchronized to the clock. A configuration input picks how it is read. In level mode, the request follows the synchronized pin. In edge mode, a falling edge sets a pending latch that the core clears with an acknowledge strobe. An enable input masks the request. A wake output tells a core that is idling or halted to resume whenever an unmasked request is present.

Top module: `boot_irq_unit`

## Requirements
- R1: While `extRstN` is low, `sysRstN` is low at once, without waiting for a clock edge. During that time `opMode` is 0 and both `irqReq` and `wakeOut` are 0.
- R2: After `extRstN` rises, `sysRstN` stays low through the first rising clock edge and goes high on the second.
- R3: `opMode` takes the value of `modePins` sampled on the clock edge where `sysRstN` goes high. Later changes of `modePins` leave `opMode` unchanged.
- R4: In edge mode (`cfgEdge`=1), a falling edge on `modePins[IRQ_PIN]` (default bit 3) sets a pending request. `irqReq` goes high on the third rising edge after the pin falls. It stays high after the pin returns high, until it is acknowledged.
- R5: When `irqAck` is high at a rising edge, the pending request is cleared at that edge.
- R6: In level mode (`cfgEdge`=0), the pin is active low. `irqReq` equals `irqEn` AND (NOT pin), and it is delayed by two rising edges.
- R7: With `irqEn`=0, `irqReq` is 0. A request latched in edge mode while masked is kept, and it appears as soon as `irqEn` returns to 1.
- R8: `wakeOut` equals `irqReq` when `coreState` is 1 (wait) or 2 (stop). It is 0 when `coreState` is 0 (running) or 3.
- R9: In edge mode, neither a pin held low nor a rising edge sets a pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| extRstN | input | 1 | Raw asynchronous active-low reset |
| modePins | input | MODE_W (4) | Boot-mode pins; bit IRQ_PIN is the interrupt pin after reset |
| cfgEdge | input | 1 | 1 = falling-edge interrupt, 0 = active-low level |
| irqEn | input | 1 | Interrupt enable (0 masks) |
| irqAck | input | 1 | Clears the pending edge request |
| coreState | input | 2 | 0 run, 1 wait, 2 stop, 3 reserved |
| sysRstN | output | 1 | Synchronized internal reset, active low |
| opMode | output | MODE_W (4) | Captured operating mode |
| irqReq | output | 1 | Masked interrupt request to the core |
| wakeOut | output | 1 | Wake request for the idle or halted core |

## Verification
The internal reset releases on the second edge after the raw reset rises, and the mode is captured on that same edge. The bench therefore checks `sysRstN` one edge after release, where it must still be low, and again after the second edge, where it must be high and `opMode` must be valid. A level on the pin reaches `irqReq` two edges after it is driven, and an edge request reaches `irqReq` on the third edge. The bench checks an edge request after two edges, where it must still be absent, and again after the third. Acknowledge takes effect one edge after it is driven. Mask changes and `coreState` changes act combinationally. Inputs are driven, and outputs sampled, one nanosecond after a rising edge.

// File: rtl/boot_irq_pkg.sv
package boot_irq_pkg;
  typedef enum logic [1:0] {
    CORE_RUN  = 2'd0,
    CORE_WAIT = 2'd1,
    CORE_STOP = 2'd2,
    CORE_RSVD = 2'd3
  } coreState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic captureMode;  // internal reset releases this edge
    logic pendSet;      // falling edge seen in edge mode
    logic pendClr;      // acknowledge or level mode
    logic levelActive;  // synchronized pin is low
    logic useEdge;      // edge mode selected
  } irqStrobes_t;
endpackage

// File: rtl/boot_irq_ctrl.sv
module boot_irq_ctrl
  import boot_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        extRstN,
  input  logic        irqPinRaw,
  input  logic        cfgEdge,
  input  logic        irqAck,
  output logic        sysRstN,
  output irqStrobes_t strobes
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] rstChain;
  logic [TOP:0] irqChain;
  logic         irqPrev;
  logic         irqSync;

  // reset release synchronizer, asynchronous assertion
  always_ff @(posedge clk or negedge extRstN) begin
    if (!extRstN) rstChain <= '0;
    else          rstChain <= {rstChain[TOP-1:0], 1'b1};
  end
  assign sysRstN = rstChain[TOP];

  // interrupt pin synchronizer, idle level is high
  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      irqChain <= '1;
      irqPrev  <= 1'b1;
    end else begin
      irqChain <= {irqChain[TOP-1:0], irqPinRaw};
      irqPrev  <= irqSync;
    end
  end
  assign irqSync = irqChain[TOP];

  always_comb begin
    strobes.captureMode = rstChain[TOP-1] & ~rstChain[TOP];
    strobes.pendSet     = cfgEdge & irqPrev & ~irqSync;
    strobes.pendClr     = irqAck | ~cfgEdge;
    strobes.levelActive = ~irqSync;
    strobes.useEdge     = cfgEdge;
  end

  // R2: internal release only follows an already released raw reset
  p_release_after_raw_r2: assert property (@(posedge clk) disable iff (!extRstN)
    $rose(sysRstN) |-> $past(extRstN));
endmodule

// File: rtl/boot_irq_dp.sv
module boot_irq_dp
  import boot_irq_pkg::*;
#(
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              extRstN,
  input  logic              sysRstN,
  input  logic [MODE_W-1:0] modePins,
  input  irqStrobes_t       strobes,
  input  logic              irqEn,
  input  logic [1:0]        coreState,
  input  logic              irqAck,
  output logic [MODE_W-1:0] opMode,
  output logic              irqReq,
  output logic              wakeOut
);
  logic pending;
  logic idleState;

  always_ff @(posedge clk or negedge extRstN) begin
    if (!extRstN)                opMode <= '0;
    else if (strobes.captureMode) opMode <= modePins;
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)              pending <= 1'b0;
    else if (strobes.pendSet)  pending <= 1'b1;
    else if (strobes.pendClr)  pending <= 1'b0;
  end

  always_comb begin
    idleState = (coreState == CORE_WAIT) || (coreState == CORE_STOP);
    irqReq    = sysRstN & irqEn & (strobes.useEdge ? pending : strobes.levelActive);
    wakeOut   = irqReq & idleState;
  end

  p_mode_hold_r3: assert property (@(posedge clk) disable iff (!extRstN)
    sysRstN && $past(sysRstN) |-> $stable(opMode));
  p_edge_sets_r4: assert property (@(posedge clk) disable iff (!sysRstN)
    strobes.pendSet |=> pending);
  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!sysRstN)
    irqAck && !strobes.pendSet |=> !pending);
  p_mask_r7: assert property (@(posedge clk) disable iff (!sysRstN)
    !irqEn |-> !irqReq);
  p_no_wake_run_r8: assert property (@(posedge clk) disable iff (!sysRstN)
    (coreState == CORE_RUN) |-> !wakeOut);
endmodule

// File: rtl/boot_irq_unit.sv
module boot_irq_unit
  import boot_irq_pkg::*;
#(
  parameter int MODE_W      = 4,
  parameter int IRQ_PIN     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              extRstN,
  input  logic [MODE_W-1:0] modePins,
  input  logic              cfgEdge,
  input  logic              irqEn,
  input  logic              irqAck,
  input  logic [1:0]        coreState,
  output logic              sysRstN,
  output logic [MODE_W-1:0] opMode,
  output logic              irqReq,
  output logic              wakeOut
);
  irqStrobes_t strobes;

  boot_irq_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .extRstN(extRstN), .irqPinRaw(modePins[IRQ_PIN]),
    .cfgEdge(cfgEdge), .irqAck(irqAck), .sysRstN(sysRstN), .strobes(strobes)
  );

  boot_irq_dp #(.MODE_W(MODE_W)) uDp (
    .clk(clk), .extRstN(extRstN), .sysRstN(sysRstN), .modePins(modePins),
    .strobes(strobes), .irqEn(irqEn), .coreState(coreState), .irqAck(irqAck),
    .opMode(opMode), .irqReq(irqReq), .wakeOut(wakeOut)
  );
endmodule

// File: tb/tb_boot_irq_unit.sv
`timescale 1ns/1ps
module tb_boot_irq_unit;
  logic       clk = 1'b0;
  logic       extRstN = 1'b0;
  logic [3:0] pins = 4'b1000;
  logic       cfgEdge = 1'b0, irqEn = 1'b0, irqAck = 1'b0;
  logic [1:0] coreState = 2'd0;
  logic       sysRstN, irqReq, wakeOut;
  logic [3:0] opMode;
  int nChecks = 0, nFails = 0;

  boot_irq_unit dut (
    .clk(clk), .extRstN(extRstN), .modePins(pins), .cfgEdge(cfgEdge),
    .irqEn(irqEn), .irqAck(irqAck), .coreState(coreState),
    .sysRstN(sysRstN), .opMode(opMode), .irqReq(irqReq), .wakeOut(wakeOut)
  );

  always #2 clk = ~clk;  // 250 MHz

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expWake(input string req, input logic r);
    for (int c = 0; c < 4; c++) begin
      coreState = 2'(c);
      #0.5;
      chk(req, {3'b0, wakeOut}, {3'b0, r && (c == 1 || c == 2)});
    end
    coreState = 2'd0;
  endtask

  initial begin
    #(4 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    cyc(2);
    // R1: reset state
    chk("R1", {3'b0, sysRstN}, 4'h0);
    chk("R1", opMode, 4'h0);
    chk("R1", {2'b0, irqReq, wakeOut}, 4'h0);
    // R2/R3: capture sweep over all 16 modes
    for (int m = 0; m < 16; m++) begin
      extRstN = 1'b0; pins = 4'(m);
      #1 chk("R1", {3'b0, sysRstN}, 4'h0);
      cyc(1);
      extRstN = 1'b1;
      cyc(1);
      chk("R2", {3'b0, sysRstN}, 4'h0);
      cyc(1);
      chk("R2", {3'b0, sysRstN}, 4'h1);
      pins = ~4'(m);
      cyc(2);
      chk("R3", opMode, 4'(m));
    end
    // R6/R7/R8: level mode sweep
    pins = 4'b1000; cfgEdge = 1'b0;
    for (int e = 0; e < 2; e++)
      for (int p = 0; p < 2; p++) begin
        irqEn = 1'(e); pins[3] = 1'(p);
        cyc(1);
        if (e == 1 && p == 0) chk("R6", {3'b0, irqReq}, 4'h0);
        cyc(1);
        chk(e ? "R6" : "R7", {3'b0, irqReq}, {3'b0, e == 1 && p == 0});
        expWake("R8", e == 1 && p == 0);
      end
    // edge mode
    pins[3] = 1'b1; irqEn = 1'b1;
    cyc(3);
    cfgEdge = 1'b1;
    cyc(1);
    chk("R9", {3'b0, irqReq}, 4'h0);
    pins[3] = 1'b0;
    cyc(2);
    chk("R4", {3'b0, irqReq}, 4'h0);
    cyc(1);
    chk("R4", {3'b0, irqReq}, 4'h1);
    expWake("R8", 1'b1);
    pins[3] = 1'b1;
    cyc(4);
    chk("R4", {3'b0, irqReq}, 4'h1);
    irqAck = 1'b1; cyc(1); irqAck = 1'b0;
    chk("R5", {3'b0, irqReq}, 4'h0);
    // R9: held low after ack, then rising edge
    pins[3] = 1'b0; cyc(4);
    irqAck = 1'b1; cyc(1); irqAck = 1'b0;
    cyc(5);
    chk("R9", {3'b0, irqReq}, 4'h0);
    pins[3] = 1'b1; cyc(5);
    chk("R9", {3'b0, irqReq}, 4'h0);
    // R7: masked edge kept
    irqEn = 1'b0;
    pins[3] = 1'b0; cyc(5);
    chk("R7", {3'b0, irqReq}, 4'h0);
    expWake("R7", 1'b0);
    irqEn = 1'b1; #0.5;
    chk("R7", {3'b0, irqReq}, 4'h1);
    // R1: reset drops request at once
    extRstN = 1'b0; #1;
    chk("R1", {3'b0, sysRstN}, 4'h0);
    chk("R1", {2'b0, irqReq, wakeOut}, 4'h0);
    chk("R1", opMode, 4'h0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule